// File: doc/BRIEF.md
# Synchronizable PWM Time-Base with Double-Buffered Period and Compare

This block is an up-counting time-base for pulse-width modulation. Period and compare values are double-buffered. Software writes a value into a shadow copy through a write strobe. The shadow value moves into the active copy only on a load event, so a value changed in mid-cycle never cuts a PWM cycle short. A phase register is written directly. A sync pulse on the input copies the phase value into the counter, which lets several instances run in a fixed phase relation for interleaved multiphase converters.

A leader instance drives a follower by wiring the leader's sync output, which is its zero event, to the follower's sync input. A mode input selects when loads happen. In one mode the active registers reload only at counter zero. In the other they also reload on a sync pulse. With the second mode, a frequency change takes effect in leader and follower on the same edge, and the interleave stays correct from the first new cycle.

Top module: `pwm_timebase`

## Requirements
- R1: When the counter is zero, the active period and active compare each take their shadow value at the next clock edge, whatever the mode.
- R2: A sync pulse (`sync_in` high for one clock) loads the counter with the phase register at the next edge. `phs_wr` updates the phase register at once, with no shadow copy.
- R3: With `sync_load_en`=1, a sync pulse also loads both active registers from their shadows at the same edge. With `sync_load_en`=0, a sync pulse leaves both active registers unchanged.
- R4: The counter counts up by one per clock from 0 to the active period and then returns to 0, so one cycle lasts period+1 clocks. `prd_evt` is high for exactly one clock per cycle, the clock in which the counter equals the active period.
- R5: If the counter holds a value above the active period, it keeps counting up to 2^CNT_W-1 and wraps to 0. With CNT_W=16, period 6 and a phase of 50 loaded in mode 0, the next zero comes 65486 clocks after the counter shows 50, and there is no `prd_evt` in between.
- R6: When the follower's `sync_in` is the leader's `sync_out`, the follower's zero event comes Pf+2-phase clocks after the leader's, where Pf is the follower's active period. With period 599 and phase 200 this is 401 clocks.
- R7: `zero_evt` and `sync_out` are high in each clock in which the counter is zero. `pwm_out` is high while the counter is below the active compare value. `cmp_evt` is high while the counter equals it. Reset clears the counter and sets shadow and active values to RST_PRD and RST_CMP.
- R8: A shadow write in the same clock as a load event transfers the shadow's previous value. The newly written value waits for the next load event.
- R9: A sync pulse in the clock in which the counter equals the period wins over the return to zero, and the counter takes the phase value. When sync and load fall in the same clock, the next period comparison already uses the new period.
- R10: With `sync_load_en`=0, suppose a new period and phase are written after the follower's zero but before the leader's next zero. The follower then runs once on its old period. With old period 599, new period 1199 and new phase 400, it shows an offset of 201 clocks and then 801.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prd_wr | input | 1 | Write strobe for the period shadow |
| prd_wdata | input | CNT_W | Period shadow write data |
| cmp_wr | input | 1 | Write strobe for the compare shadow |
| cmp_wdata | input | CNT_W | Compare shadow write data |
| phs_wr | input | 1 | Write strobe for the phase register |
| phs_wdata | input | CNT_W | Phase write data |
| sync_load_en | input | 1 | 1: shadows also load on sync; 0: zero-only loading |
| sync_in | input | 1 | Sync pulse: loads the phase into the counter |
| zero_evt | output | 1 | High while the counter is zero |
| prd_evt | output | 1 | High while the counter equals the active period |
| cmp_evt | output | 1 | High while the counter equals the active compare |
| pwm_out | output | 1 | High while the counter is below the active compare |
| sync_out | output | 1 | Zero event for chaining a follower |

## Verification
Counter and active registers change at the rising edge after a stimulus. All four event outputs and `pwm_out` are decoded without a register from that state, so a strobe or sync pulse driven before an edge is visible at the next falling edge. A follower therefore shows the phase value one clock after the leader's zero. The bench drives and samples only on falling edges. It measures cycle lengths, pulse counts and leader-to-follower offsets by counting falling edges between event pulses. It compares each count with a figure derived from period, phase and compare, for example period+1, Pf+2-phase, or 2^16 minus the phase for the overrun.

// File: rtl/ptb_pkg.sv
package ptb_pkg;

    localparam int unsigned CNT_W_DEF = 16;
    localparam int unsigned NUM_BUF   = 2;
    localparam int unsigned IDX_PRD   = 0;
    localparam int unsigned IDX_CMP   = 1;

    typedef enum logic {
        LD_ZERO_ONLY     = 1'b0,
        LD_ZERO_AND_SYNC = 1'b1
    } ld_mode_e;

    typedef struct packed {
        logic zero;
        logic period;
        logic compare;
        logic below;
    } tb_flags_t;

    function automatic logic load_fire(input logic at_zero, input logic sync,
                                       input ld_mode_e mode);
        return at_zero | (sync & (mode == LD_ZERO_AND_SYNC));
    endfunction

endpackage

// File: rtl/ptb_dbuf.sv
module ptb_dbuf #(
    parameter int unsigned W       = 16,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         load,
    output logic [W-1:0] shadow,
    output logic [W-1:0] active
);

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow <= RST_VAL;
            active <= RST_VAL;
        end else begin
            if (wr)
                shadow <= wdata;
            if (load)
                active <= shadow;
        end
    end

endmodule

// File: rtl/ptb_counter.sv
module ptb_counter #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         sync,
    input  logic [W-1:0] phase,
    input  logic         period_hit,
    output logic [W-1:0] count
);

    always_ff @(posedge clk) begin
        if (rst)
            count <= '0;
        else if (sync)
            count <= phase;
        else if (period_hit)
            count <= '0;
        else
            count <= count + W'(1);
    end

endmodule

// File: rtl/ptb_compare.sv
module ptb_compare
    import ptb_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] count,
    input  logic [W-1:0] period,
    input  logic [W-1:0] cmp,
    output tb_flags_t    flags
);

    always_comb begin
        flags.zero    = (count == '0);
        flags.period  = (count == period);
        flags.compare = (count == cmp);
        flags.below   = (count < cmp);
    end

endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
    import ptb_pkg::*;
#(
    parameter int unsigned CNT_W = CNT_W_DEF,
    parameter logic [CNT_W-1:0] RST_PRD = {CNT_W{1'b1}},
    parameter logic [CNT_W-1:0] RST_CMP = '0,
    parameter logic [CNT_W-1:0] RST_PHS = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             prd_wr,
    input  logic [CNT_W-1:0] prd_wdata,
    input  logic             cmp_wr,
    input  logic [CNT_W-1:0] cmp_wdata,
    input  logic             phs_wr,
    input  logic [CNT_W-1:0] phs_wdata,
    input  logic             sync_load_en,
    input  logic             sync_in,
    output logic             zero_evt,
    output logic             prd_evt,
    output logic             cmp_evt,
    output logic             pwm_out,
    output logic             sync_out
);

    localparam logic [NUM_BUF-1:0][CNT_W-1:0] BUF_RST = {RST_CMP, RST_PRD};

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] phs_q;
    logic [NUM_BUF-1:0]            buf_wr;
    logic [NUM_BUF-1:0][CNT_W-1:0] buf_wdata;
    logic [NUM_BUF-1:0][CNT_W-1:0] buf_shd;
    logic [NUM_BUF-1:0][CNT_W-1:0] buf_act;
    logic [CNT_W-1:0] shd_prd, shd_cmp, act_prd, act_cmp;
    tb_flags_t        flags;
    ld_mode_e         mode;
    logic             load;

    assign buf_wr[IDX_PRD]    = prd_wr;
    assign buf_wr[IDX_CMP]    = cmp_wr;
    assign buf_wdata[IDX_PRD] = prd_wdata;
    assign buf_wdata[IDX_CMP] = cmp_wdata;

    assign mode = ld_mode_e'(sync_load_en);
    assign load = load_fire(flags.zero, sync_in, mode);

    for (genvar i = 0; i < NUM_BUF; i++) begin : g_buf
        ptb_dbuf #(
            .W      (CNT_W),
            .RST_VAL(BUF_RST[i])
        ) u_dbuf (
            .clk   (clk),
            .rst   (rst),
            .wr    (buf_wr[i]),
            .wdata (buf_wdata[i]),
            .load  (load),
            .shadow(buf_shd[i]),
            .active(buf_act[i])
        );
    end

    assign shd_prd = buf_shd[IDX_PRD];
    assign shd_cmp = buf_shd[IDX_CMP];
    assign act_prd = buf_act[IDX_PRD];
    assign act_cmp = buf_act[IDX_CMP];

    always_ff @(posedge clk) begin
        if (rst)
            phs_q <= RST_PHS;
        else if (phs_wr)
            phs_q <= phs_wdata;
    end

    ptb_compare #(.W(CNT_W)) u_cmp (
        .count (cnt_q),
        .period(act_prd),
        .cmp   (act_cmp),
        .flags (flags)
    );

    ptb_counter #(.W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .sync      (sync_in),
        .phase     (phs_q),
        .period_hit(flags.period),
        .count     (cnt_q)
    );

    assign zero_evt = flags.zero;
    assign sync_out = flags.zero;
    assign prd_evt  = flags.period;
    assign cmp_evt  = flags.compare;
    assign pwm_out  = flags.below;

endmodule

// File: rtl/pwm_timebase_chk.sv
module pwm_timebase_chk #(
    parameter int unsigned W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic         sync_in,
    input logic         sync_load_en,
    input logic [W-1:0] cnt,
    input logic [W-1:0] phs,
    input logic [W-1:0] shd_prd,
    input logic [W-1:0] shd_cmp,
    input logic [W-1:0] act_prd,
    input logic [W-1:0] act_cmp
);

    // R2 and R9: sync loads the phase, ahead of the period reset
    a_r2_phase_load: assert property (@(posedge clk) disable iff (rst)
        sync_in |=> (cnt == $past(phs)));

    // R1 and R8: zero-count load moves the pre-edge shadow values
    a_r1_zero_load: assert property (@(posedge clk) disable iff (rst)
        (cnt == '0) |=> (act_prd == $past(shd_prd) && act_cmp == $past(shd_cmp)));

    // R3: sync load when enabled
    a_r3_sync_load: assert property (@(posedge clk) disable iff (rst)
        (sync_in && sync_load_en) |=> (act_prd == $past(shd_prd) && act_cmp == $past(shd_cmp)));

    // R3: no other load source
    a_r3_no_stray_load: assert property (@(posedge clk) disable iff (rst)
        (cnt != '0 && !(sync_in && sync_load_en)) |=> ($stable(act_prd) && $stable(act_cmp)));

    // R4: period match returns the counter to zero
    a_r4_period_reset: assert property (@(posedge clk) disable iff (rst)
        (!sync_in && cnt == act_prd) |=> (cnt == '0));

    // R5: otherwise count up by one, wrapping at full width
    a_r5_count_up: assert property (@(posedge clk) disable iff (rst)
        (!sync_in && cnt != act_prd) |=> (cnt == $past(cnt) + W'(1)));

endmodule

bind pwm_timebase pwm_timebase_chk #(.W(CNT_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .sync_in     (sync_in),
    .sync_load_en(sync_load_en),
    .cnt         (cnt_q),
    .phs         (phs_q),
    .shd_prd     (shd_prd),
    .shd_cmp     (shd_cmp),
    .act_prd     (act_prd),
    .act_cmp     (act_cmp)
);

// File: tb/tb_pwm_timebase.sv
module tb_pwm_timebase;

    localparam int W = 16;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst = 1'b1;
    logic l_pw = 0, l_cw = 0, l_hw = 0, l_mode = 0, l_sync = 0;
    logic [W-1:0] l_pd = '0, l_cd = '0, l_hd = '0;
    logic f_pw = 0, f_cw = 0, f_hw = 0, f_mode = 0, link = 0;
    logic [W-1:0] f_pd = '0, f_cd = '0, f_hd = '0;
    logic l_zero, l_prd, l_cmp, l_pwm, l_so;
    logic f_zero, f_prd, f_cmp, f_pwm, f_so;
    logic f_sync;

    assign f_sync = link & l_so;

    pwm_timebase #(.CNT_W(W), .RST_PRD(16'd599), .RST_CMP(16'd300)) dut (
        .clk(clk), .rst(rst),
        .prd_wr(l_pw), .prd_wdata(l_pd), .cmp_wr(l_cw), .cmp_wdata(l_cd),
        .phs_wr(l_hw), .phs_wdata(l_hd), .sync_load_en(l_mode), .sync_in(l_sync),
        .zero_evt(l_zero), .prd_evt(l_prd), .cmp_evt(l_cmp), .pwm_out(l_pwm),
        .sync_out(l_so)
    );

    pwm_timebase #(.CNT_W(W), .RST_PRD(16'd599), .RST_CMP(16'd300)) u_follow (
        .clk(clk), .rst(rst),
        .prd_wr(f_pw), .prd_wdata(f_pd), .cmp_wr(f_cw), .cmp_wdata(f_cd),
        .phs_wr(f_hw), .phs_wdata(f_hd), .sync_load_en(f_mode), .sync_in(f_sync),
        .zero_evt(f_zero), .prd_evt(f_prd), .cmp_evt(f_cmp), .pwm_out(f_pwm),
        .sync_out(f_so)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wait_lzero();
        step();
        while (!l_zero) step();
    endtask

    // from a leader zero: cycle length, pwm-high clocks, period and compare pulses
    task automatic measure(output int n, output int hi, output int pe, output int ce);
        n = 0; hi = 0; pe = 0; ce = 0;
        do begin
            n++;
            hi += int'(l_pwm);
            pe += int'(l_prd);
            ce += int'(l_cmp);
            step();
        end while (!l_zero);
    endtask

    task automatic run_to_lzero(output int n, output int pe);
        n = 0; pe = 0;
        while (!l_zero) begin
            n++;
            pe += int'(l_prd);
            step();
        end
    endtask

    task automatic f_offset(output int n);
        n = 0;
        do begin
            step();
            n++;
        end while (!f_zero);
    endtask

    task automatic chain_run(input logic mode);
        int n;
        rst = 1'b1; link = 1'b0; l_mode = 1'b0; f_mode = mode;
        repeat (3) step();
        rst = 1'b0;
        f_hd = 16'd200; f_hw = 1'b1; link = 1'b1;
        step();
        f_hw = 1'b0;
        wait_lzero();
        wait_lzero();
        f_offset(n);
        chk("R6 steady follower offset", n, 599 + 2 - 200);
        step();
        l_pd = 16'd1199; l_cd = 16'd600; l_pw = 1'b1; l_cw = 1'b1;
        f_pd = 16'd1199; f_cd = 16'd600; f_pw = 1'b1; f_cw = 1'b1;
        f_hd = 16'd400; f_hw = 1'b1;
        step();
        l_pw = 0; l_cw = 0; f_pw = 0; f_cw = 0; f_hw = 0;
        wait_lzero();
        f_offset(n);
        if (mode)
            chk("R3 sync load first offset after change", n, 1199 + 2 - 400);
        else
            chk("R10 transient offset on old period", n, 599 + 2 - 400);
        wait_lzero();
        f_offset(n);
        chk("R6 offset after settling", n, 1199 + 2 - 400);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int n, hi, pe, ce;
        // reset state
        repeat (3) step();
        chk("R7 reset zero_evt", int'(l_zero), 1);
        chk("R7 reset sync_out", int'(l_so), 1);
        chk("R7 reset pwm_out", int'(l_pwm), 1);
        chk("R7 reset prd_evt/cmp_evt", int'(l_prd) + int'(l_cmp), 0);
        rst = 1'b0;
        step();

        // period sweep, zero-count loading
        for (int p = 4; p <= 9; p++) begin
            l_pd = W'(p); l_cd = W'(p / 2); l_pw = 1'b1; l_cw = 1'b1;
            step();
            l_pw = 1'b0; l_cw = 1'b0;
            wait_lzero();
            measure(n, hi, pe, ce);
            chk("R1 R4 cycle length", n, p + 1);
            chk("R7 pwm high clocks", hi, p / 2);
            chk("R4 prd_evt pulses", pe, 1);
            chk("R7 cmp_evt pulses", ce, 1);
        end

        // write coinciding with zero load (current cycle is a zero)
        l_pd = 16'd6; l_pw = 1'b1;
        measure(n, hi, pe, ce);
        l_pw = 1'b0;
        chk("R8 old shadow transferred", n, 10);
        measure(n, hi, pe, ce);
        chk("R8 new value at next load", n, 7);

        // phase above period, mode 0
        l_hd = 16'd50; l_hw = 1'b1;
        step();
        l_hw = 1'b0; l_sync = 1'b1;
        step();
        l_sync = 1'b0;
        run_to_lzero(n, pe);
        chk("R5 wrap distance", n, 65536 - 50);
        chk("R5 no prd_evt while above", pe, 0);

        // sync loading modes on one instance
        rst = 1'b1; l_mode = 1'b0;
        repeat (3) step();
        rst = 1'b0;
        l_hd = 16'd5; l_hw = 1'b1; l_pd = 16'd20; l_pw = 1'b1;
        step();
        l_hw = 1'b0; l_pw = 1'b0; l_sync = 1'b1;
        step();
        l_sync = 1'b0;
        run_to_lzero(n, pe);
        chk("R2 R3 mode0 sync keeps old period", n, 599 - 5 + 1);
        step(); step();
        l_pd = 16'd40; l_pw = 1'b1;
        step();
        l_pw = 1'b0; l_mode = 1'b1; l_sync = 1'b1;
        step();
        l_sync = 1'b0; l_mode = 1'b0;
        run_to_lzero(n, pe);
        chk("R3 mode1 sync loads new period", n, 40 - 5 + 1);
        step();
        while (!l_prd) step();
        l_sync = 1'b1;
        step();
        l_sync = 1'b0;
        run_to_lzero(n, pe);
        chk("R9 sync wins over period reset", n, 40 - 5 + 1);

        // chained leader and follower
        chain_run(1'b0);
        chain_run(1'b1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule